// File: doc/BRIEF.md
# Link Speed Step-Down Bring-Up Sequencer

This block brings a PCIe link up in two phases. It first pins the supported-link-speed field of the link-capabilities register to the 2.5 GT/s code so that training begins at the slowest rate. Once the link is up, it puts back the speed the port originally advertised and asks for a retrain. All of this happens through a single register-port master with a request/acknowledge handshake and a 32-bit data bus. The training logic itself sits outside the block. The block only writes the training-enable register and watches a `link_up` input.

A single `start` pulse runs the sequence. Before it modifies the capability register, the block opens write access to read-only configuration registers. It closes that access again at the end of every run, on success and on failure alike. A wait that times out ends the run early with a failure code. The retrain phase is skipped when the speed field read after link-up already equals the saved value. At the end the block gives a one-cycle `done` pulse together with a status code.

Top module: `link_speed_stepdown`

## Requirements
- R1: While idle, a `start` pulse begins a run whose first access writes 1 to the unlock address (default 0x8BC). A `start` that arrives while `busy` is high is ignored.
- R2: Next the block reads the capability address (default 0x07C) and saves bits [3:0]. It then writes the value back with bits [3:0] set to 1 (the 2.5 GT/s code) and every other bit unchanged. The unlock register must read 1 at the time of that write.
- R3: After the forced write, the block writes 1 to the training-enable address (default 0x010) and then waits for `link_up` to be high.
- R4: If `link_up` does not go high within LINK_TIMEOUT cycles of the wait, the status becomes 1 (initial-link failure) and the block goes straight to re-locking.
- R5: After link-up, the block reads the capability address again. If bits [3:0] equal the saved value, the only remaining access is the re-lock, and the status becomes 0 (ok).
- R6: If bits [3:0] differ from the saved value, the block writes the re-read value back with bits [3:0] set to the saved value. It then reads the port control address (default 0x80C) and writes it back with bit 17 (speed change) set and all other bits kept.
- R7: After the speed-change write, the block waits for `link_up` again under the same timeout. Success gives status 0. A timeout gives status 2 (retrain failure).
- R8: Every run ends by writing 0 to the unlock address, followed by `done` high for exactly one cycle. `busy` is high from the accepted `start` through the `done` cycle. `status` holds its value until the next accepted `start`.
- R9: `reg_req` stays high, with `reg_we`, `reg_addr` and `reg_wdata` stable, until `reg_ack` is sampled high. Only one access is outstanding at any time.
- R10: After reset, `reg_req`, `done` and `busy` are 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that begins a bring-up run |
| link_up | input | 1 | Link-up indication from the training logic |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 ok, 1 initial link failure, 2 retrain failure |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | Access completed; read data valid |
| reg_rdata | input | DATA_W | Read data |

## Verification
A wrong saved speed field or a bad comparison shows up right after link-up, as an extra or a missing restore/retrain access in the register log. A corrupted merge mask shows up in the forced write or the restore write data at the first write that uses it. A timer or wait-state fault changes the status code or the number of accesses seen before `done`. A fault on the unlock path leaves the unlock register at 1 after `done`, or at 0 while the capability register is being written. The bench compares every logged access against values derived from the requirements.

// File: rtl/lsf_pkg.sv
// Package: shared types for the link speed step-down sequencer.
// Assumes: status encoding is visible at the top port as a 2-bit code.
package lsf_pkg;

    // End-of-run result code.
    typedef enum logic [1:0] {
        LSF_OK           = 2'd0,
        LSF_INIT_FAIL    = 2'd1,
        LSF_RETRAIN_FAIL = 2'd2
    } lsf_status_e;

    // Sequencer steps, in run order.
    typedef enum logic [3:0] {
        S_IDLE,
        S_UNLOCK,
        S_RD_CAP,
        S_FORCE,
        S_TRAIN,
        S_WAIT1,
        S_REREAD,
        S_RESTORE,
        S_RD_CTL,
        S_SET_CHG,
        S_WAIT2,
        S_LOCK,
        S_DONE
    } lsf_state_e;

endpackage

// File: rtl/lsf_reg_port.sv
// Module: lsf_reg_port
// Single-outstanding register access master. It accepts one command while
// idle, holds req/we/addr/wdata until ack is sampled high, then gives a
// one-cycle completion pulse with the captured read data.
// Assumes: ack is only meaningful while req is high.
module lsf_reg_port #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              cmd_done,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic done_q;

    assign cmd_ready = !reg_req && !done_q;
    assign cmd_done  = done_q;

    // Issue, hold and retire one access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_req   <= 1'b0;
            reg_we    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            done_q    <= 1'b0;
            cmd_rdata <= '0;
        end else begin
            done_q <= 1'b0;
            if (reg_req) begin
                if (reg_ack) begin
                    reg_req   <= 1'b0;
                    done_q    <= 1'b1;
                    cmd_rdata <= reg_rdata;
                end
            end else if (cmd_valid && cmd_ready) begin
                reg_req   <= 1'b1;
                reg_we    <= cmd_we;
                reg_addr  <= cmd_addr;
                reg_wdata <= cmd_wdata;
            end
        end
    end

    // R9: request held until acknowledged.
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> reg_req);

    // R9: address, direction and data stable while pending.
    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> ($stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    // R9: no completion pulse twice in a row.
    assert_single_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/lsf_link_timer.sv
// Module: lsf_link_timer
// Counts cycles spent waiting for link-up. It clears whenever run is low
// and flags expiry on the LIMIT-th cycle of a continuous run.
// Assumes: LIMIT >= 2.
module lsf_link_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == LAST);

    // Cycle counter for one wait window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: counter never passes the timeout limit.
    assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/lsf_sequencer.sv
// Module: lsf_sequencer
// Step sequencer for the two-phase speed bring-up. It drives one register
// command per access step, merges the speed field into read data, runs the
// link-up waits and records the end status.
// Assumes: the register port completes each command with a one-cycle pulse.
module lsf_sequencer
    import lsf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SPD_LSB = 0,
    parameter int SPD_W = 4,
    parameter int BASE_SPD = 1,
    parameter int CHG_BIT = 17,
    parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h07C,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h80C,
    parameter logic [ADDR_W-1:0] TRAIN_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 12'h8BC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              link_up,
    input  logic              tmr_expired,
    output logic              tmr_run,
    output logic              cmd_valid,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ready,
    input  logic              cmd_done,
    input  logic [DATA_W-1:0] cmd_rdata,
    output logic              busy,
    output logic              done,
    output lsf_status_e       status
);

    localparam logic [DATA_W-1:0] FLD_MASK = DATA_W'(((64'd1 << SPD_W) - 64'd1) << SPD_LSB);
    localparam logic [DATA_W-1:0] BASE_VAL = DATA_W'(64'(BASE_SPD) << SPD_LSB);
    localparam logic [DATA_W-1:0] CHG_VAL  = DATA_W'(64'd1 << CHG_BIT);

    lsf_state_e        state_q;
    logic              issued_q;
    logic [DATA_W-1:0] cap_q;
    logic [DATA_W-1:0] ctl_q;
    logic [SPD_W-1:0]  saved_q;
    logic              unlocked_q;
    logic              is_access;
    logic [SPD_W-1:0]  reread_fld;

    assign busy       = (state_q != S_IDLE);
    assign done       = (state_q == S_DONE);
    assign tmr_run    = (state_q == S_WAIT1) || (state_q == S_WAIT2);
    assign reread_fld = cmd_rdata[SPD_LSB +: SPD_W];

    // Which steps issue a register command.
    always_comb begin
        case (state_q)
            S_UNLOCK, S_RD_CAP, S_FORCE, S_TRAIN, S_REREAD,
            S_RESTORE, S_RD_CTL, S_SET_CHG, S_LOCK: is_access = 1'b1;
            default:                                is_access = 1'b0;
        endcase
    end

    assign cmd_valid = is_access && !issued_q && cmd_ready;

    // Command contents for the current step.
    always_comb begin
        cmd_we    = 1'b1;
        cmd_addr  = '0;
        cmd_wdata = '0;
        case (state_q)
            S_UNLOCK:  begin cmd_addr = UNLOCK_ADDR; cmd_wdata = DATA_W'(1); end
            S_RD_CAP:  begin cmd_we = 1'b0; cmd_addr = CAP_ADDR; end
            S_FORCE:   begin cmd_addr = CAP_ADDR; cmd_wdata = (cap_q & ~FLD_MASK) | BASE_VAL; end
            S_TRAIN:   begin cmd_addr = TRAIN_ADDR; cmd_wdata = DATA_W'(1); end
            S_REREAD:  begin cmd_we = 1'b0; cmd_addr = CAP_ADDR; end
            S_RESTORE: begin
                cmd_addr  = CAP_ADDR;
                cmd_wdata = (cap_q & ~FLD_MASK) | (DATA_W'(saved_q) << SPD_LSB);
            end
            S_RD_CTL:  begin cmd_we = 1'b0; cmd_addr = CTL_ADDR; end
            S_SET_CHG: begin cmd_addr = CTL_ADDR; cmd_wdata = ctl_q | CHG_VAL; end
            S_LOCK:    begin cmd_addr = UNLOCK_ADDR; cmd_wdata = '0; end
            default:   cmd_we = 1'b0;
        endcase
    end

    // Step progression, captured data and end status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            issued_q   <= 1'b0;
            cap_q      <= '0;
            ctl_q      <= '0;
            saved_q    <= '0;
            unlocked_q <= 1'b0;
            status     <= LSF_OK;
        end else begin
            if (cmd_valid) issued_q <= 1'b1;
            if (cmd_done)  issued_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    status  <= LSF_OK;
                    state_q <= S_UNLOCK;
                end
                S_UNLOCK: if (cmd_done) begin
                    unlocked_q <= 1'b1;
                    state_q    <= S_RD_CAP;
                end
                S_RD_CAP: if (cmd_done) begin
                    cap_q   <= cmd_rdata;
                    saved_q <= reread_fld;
                    state_q <= S_FORCE;
                end
                S_FORCE: if (cmd_done) state_q <= S_TRAIN;
                S_TRAIN: if (cmd_done) state_q <= S_WAIT1;
                S_WAIT1: begin
                    if (link_up) begin
                        state_q <= S_REREAD;
                    end else if (tmr_expired) begin
                        status  <= LSF_INIT_FAIL;
                        state_q <= S_LOCK;
                    end
                end
                S_REREAD: if (cmd_done) begin
                    cap_q <= cmd_rdata;
                    if (reread_fld != saved_q) state_q <= S_RESTORE;
                    else                       state_q <= S_LOCK;
                end
                S_RESTORE: if (cmd_done) state_q <= S_RD_CTL;
                S_RD_CTL: if (cmd_done) begin
                    ctl_q   <= cmd_rdata;
                    state_q <= S_SET_CHG;
                end
                S_SET_CHG: if (cmd_done) state_q <= S_WAIT2;
                S_WAIT2: begin
                    if (link_up) begin
                        state_q <= S_LOCK;
                    end else if (tmr_expired) begin
                        status  <= LSF_RETRAIN_FAIL;
                        state_q <= S_LOCK;
                    end
                end
                S_LOCK: if (cmd_done) begin
                    unlocked_q <= 1'b0;
                    state_q    <= S_DONE;
                end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R8: end-of-run pulse lasts one cycle.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: read-only write access is closed before done.
    assert_relocked_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !unlocked_q);

    // R2: the forced write only happens with write access open.
    assert_unlocked_for_force_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FORCE) |-> unlocked_q);

    // R4: leaving the first wait without link-up records initial failure.
    assert_init_fail_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == S_WAIT1 && state_q == S_LOCK) |-> (status == LSF_INIT_FAIL));

    // R6: restore step only when the reread field differs from the saved one.
    assert_restore_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESTORE) |-> (cap_q[SPD_LSB +: SPD_W] != saved_q));

endmodule

// File: rtl/link_speed_stepdown.sv
// Module: link_speed_stepdown
// Top of the two-phase link speed bring-up: forces the lowest speed code,
// enables training, waits for link-up, then restores the saved speed and
// requests a retrain when the field changed. Result reported with done.
// Assumes: link_up is synchronous to clk; all registers sit behind one port.
module link_speed_stepdown
    import lsf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SPD_LSB = 0,
    parameter int SPD_W = 4,
    parameter int BASE_SPD = 1,
    parameter int CHG_BIT = 17,
    parameter int LINK_TIMEOUT = 100000,
    parameter logic [ADDR_W-1:0] CAP_ADDR = 12'h07C,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h80C,
    parameter logic [ADDR_W-1:0] TRAIN_ADDR = 12'h010,
    parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 12'h8BC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              link_up,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata
);

    logic              cmd_valid;
    logic              cmd_we;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              cmd_ready;
    logic              cmd_done;
    logic [DATA_W-1:0] cmd_rdata;
    logic              tmr_run;
    logic              tmr_expired;
    lsf_status_e       status_e;

    assign status = status_e;

    lsf_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_LSB(SPD_LSB), .SPD_W(SPD_W),
        .BASE_SPD(BASE_SPD), .CHG_BIT(CHG_BIT), .CAP_ADDR(CAP_ADDR),
        .CTL_ADDR(CTL_ADDR), .TRAIN_ADDR(TRAIN_ADDR), .UNLOCK_ADDR(UNLOCK_ADDR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
        .tmr_expired(tmr_expired), .tmr_run(tmr_run),
        .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .cmd_done(cmd_done),
        .cmd_rdata(cmd_rdata), .busy(busy), .done(done), .status(status_e)
    );

    lsf_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    lsf_link_timer #(.LIMIT(LINK_TIMEOUT)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_expired)
    );

endmodule

// File: tb/link_speed_stepdown_tb.sv
// Directed bench: a register model answers the port, a link model raises
// link_up after programmed delays, and each scenario task checks its log.
module link_speed_stepdown_tb;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam logic [AW-1:0] A_CAP = 12'h07C;
    localparam logic [AW-1:0] A_CTL = 12'h80C;
    localparam logic [AW-1:0] A_TRN = 12'h010;
    localparam logic [AW-1:0] A_UNL = 12'h8BC;
    localparam logic [DW-1:0] CHG  = 32'h0002_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic link_up = 1'b0;
    logic busy, done, reg_req, reg_we, reg_ack;
    logic [1:0] status;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // register model state
    logic [DW-1:0] m_cap, m_ctl, m_trn, m_unl;
    int ack_dly = 1;
    int wcnt = 0;
    logic [AW-1:0] held_addr;
    int hs_err = 0;
    // link model
    int dly1 = -1;
    int dly2 = -1;
    int lcnt = 0;
    bit larmed = 0;
    // access log
    logic          lg_we [32];
    logic [AW-1:0] lg_ad [32];
    logic [DW-1:0] lg_dt [32];
    logic [DW-1:0] lg_ul [32];
    int lg_n = 0;
    int n_done = 0;

    always #4 clk = ~clk;

    link_speed_stepdown #(.LINK_TIMEOUT(200)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .link_up(link_up),
        .busy(busy), .done(done), .status(status), .reg_req(reg_req),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_rdata(reg_rdata)
    );

    initial begin reg_ack = 1'b0; reg_rdata = '0; end

    // Register responder and link model, acting on falling edges.
    always @(negedge clk) begin
        cyc++;
        if (done) n_done++;
        if (larmed) begin
            if (lcnt <= 1) begin link_up = 1'b1; larmed = 0; end
            else lcnt--;
        end
        if (reg_ack) begin
            reg_ack = 1'b0;
        end else if (reg_req) begin
            if (wcnt == 0) held_addr = reg_addr;
            else if (reg_addr != held_addr) hs_err++;
            wcnt++;
            if (wcnt >= ack_dly) begin
                wcnt = 0;
                if (lg_n < 32) begin
                    lg_we[lg_n] = reg_we;
                    lg_ad[lg_n] = reg_addr;
                    lg_ul[lg_n] = m_unl;
                end
                if (reg_we) begin
                    if (lg_n < 32) lg_dt[lg_n] = reg_wdata;
                    case (reg_addr)
                        A_CAP: m_cap = reg_wdata;
                        A_UNL: m_unl = reg_wdata;
                        A_TRN: begin
                            m_trn = reg_wdata;
                            if (reg_wdata == 32'd1 && dly1 > 0) begin lcnt = dly1; larmed = 1; end
                        end
                        A_CTL: begin
                            m_ctl = reg_wdata;
                            if ((reg_wdata & CHG) != 0) begin
                                link_up = 1'b0; larmed = 0;
                                if (dly2 > 0) begin lcnt = dly2; larmed = 1; end
                            end
                        end
                        default: ;
                    endcase
                end else begin
                    case (reg_addr)
                        A_CAP:   reg_rdata = m_cap;
                        A_CTL:   reg_rdata = m_ctl;
                        A_TRN:   reg_rdata = m_trn;
                        A_UNL:   reg_rdata = m_unl;
                        default: reg_rdata = '0;
                    endcase
                    if (lg_n < 32) lg_dt[lg_n] = reg_rdata;
                end
                lg_n++;
                reg_ack = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input int idx, input logic we, input logic [AW-1:0] ad,
                           input logic [DW-1:0] dt, input string req);
        chk(idx < lg_n && lg_we[idx] == we && lg_ad[idx] == ad && lg_dt[idx] == dt,
            req, {lg_we[idx], 7'd0, 12'(lg_ad[idx]), 12'd0}, {we, 7'd0, 12'(ad), 12'd0});
        chk(idx < lg_n && lg_dt[idx] == dt, req, lg_dt[idx], dt);
    endtask

    // Start a run, optionally poke start again while busy, wait for done.
    task automatic run(input logic [DW-1:0] cap0, input logic [DW-1:0] ctl0,
                       input int d1, input int d2, input int ackd, input bit poke);
        int guard;
        m_cap = cap0; m_ctl = ctl0; m_trn = '0; m_unl = '0;
        dly1 = d1; dly2 = d2; ack_dly = ackd; lg_n = 0; n_done = 0; hs_err = 0;
        @(negedge clk); link_up = 1'b0; larmed = 0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", 32'(busy), 32'd1);
        if (poke) begin
            repeat (10) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 5000) begin @(negedge clk); guard++; end
        chk(done == 1'b1, "R8 done seen", 32'(done), 32'd1);
    endtask

    // Common checks on the opening and closing of every run.
    task automatic check_frame(input logic [DW-1:0] cap0, input logic [1:0] exp_st,
                               input int exp_n, input string tag);
        chk(32'(status) == 32'(exp_st), {tag, " status"}, 32'(status), 32'(exp_st));
        chk(lg_n == exp_n, {tag, " access count"}, 32'(lg_n), 32'(exp_n));
        chk_acc(0, 1'b1, A_UNL, 32'd1, "R1 unlock first");
        chk_acc(1, 1'b0, A_CAP, cap0, "R2 capability read");
        chk_acc(2, 1'b1, A_CAP, (cap0 & ~32'hF) | 32'h1, "R2 forced speed write");
        chk(lg_ul[2] == 32'd1, "R2 unlocked during force", lg_ul[2], 32'd1);
        chk_acc(3, 1'b1, A_TRN, 32'd1, "R3 training enable");
        chk_acc(exp_n - 1, 1'b1, A_UNL, 32'd0, "R8 relock last");
        chk(m_unl == 32'd0, "R8 unlock register closed", m_unl, 32'd0);
        chk(hs_err == 0, "R9 address stable while pending", 32'(hs_err), 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R8 one-cycle done, idle after",
            {30'd0, done, busy}, 32'd0);
        chk(n_done == 1, "R8 single done per run", 32'(n_done), 32'd1);
        chk(32'(status) == 32'(exp_st), "R8 status held", 32'(status), 32'(exp_st));
    endtask

    task automatic t_reset();
        chk(reg_req == 1'b0, "R10 req idle", 32'(reg_req), 32'd0);
        chk(done == 1'b0 && busy == 1'b0, "R10 done/busy low", {30'd0, done, busy}, 32'd0);
        chk(status == 2'd0, "R10 status zero", 32'(status), 32'd0);
    endtask

    task automatic t_no_change();
        // saved field already 1: no retrain; second start while busy ignored (R1)
        run(32'h0070_C411, 32'h0000_0100, 20, -1, 1, 1'b1);
        check_frame(32'h0070_C411, 2'd0, 6, "R5 no change");
        chk_acc(4, 1'b0, A_CAP, 32'h0070_C411, "R5 reread");
        chk(m_ctl == 32'h0000_0100, "R5 port control untouched", m_ctl, 32'h0000_0100);
    endtask

    task automatic t_retrain_ok();
        run(32'h0070_C413, 32'h0000_0100, 30, 25, 4, 1'b0);
        check_frame(32'h0070_C413, 2'd0, 9, "R7 retrain ok");
        chk_acc(4, 1'b0, A_CAP, 32'h0070_C411, "R6 reread");
        chk_acc(5, 1'b1, A_CAP, 32'h0070_C413, "R6 restore saved speed");
        chk_acc(6, 1'b0, A_CTL, 32'h0000_0100, "R6 port control read");
        chk_acc(7, 1'b1, A_CTL, 32'h0000_0100 | CHG, "R6 speed change bit");
    endtask

    task automatic t_init_fail();
        run(32'hFFFF_FFF2, 32'h0, -1, -1, 2, 1'b0);
        check_frame(32'hFFFF_FFF2, 2'd1, 5, "R4 initial timeout");
        chk(m_cap == 32'hFFFF_FFF1, "R4 no restore after timeout", m_cap, 32'hFFFF_FFF1);
    endtask

    task automatic t_retrain_fail();
        run(32'h0000_0002, 32'h0001_0000, 150, -1, 1, 1'b0);
        check_frame(32'h0000_0002, 2'd2, 9, "R7 retrain timeout");
        chk_acc(7, 1'b1, A_CTL, 32'h0001_0000 | CHG, "R6 speed change bit kept bits");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cyc > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_change();
        t_retrain_ok();
        t_init_fail();
        t_retrain_fail();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule